// File: doc/BRIEF.md
# Serial Flash Bus Front-End

This block is the pin-side interface of a small serial flash device. It watches chip select, serial clock, serial data in, a pause pin and a write-protect pin. It hands each received byte to an instruction decoder, together with a strobe and a flag that marks the first byte of a selection as the opcode. It also shifts response bytes out on a data output that has its own enable, so the output can be put into high impedance. All pins are brought into the system clock domain through a synchronizer. Serial clock edges are found by comparing the synchronized clock with its value one cycle earlier. This means the serial clock must run well below the system clock.

Four states make up the controller:
- LOCKED is entered at reset. The only way out is to LOCKED to IDLE, once chip select is seen high, so a device that wakes up already selected ignores the traffic in progress.
- IDLE is standby. It moves to ACTIVE when chip select goes low.
- ACTIVE samples data on rising clock edges and launches output on falling edges. It moves to HOLD when the pause pin goes low, and back to IDLE when chip select goes high.
- HOLD freezes all shifting. It returns to ACTIVE when the pause pin goes high, and to IDLE when chip select goes high.

Bytes for transmission are written through a parallel load strobe. A loaded byte starts on the first falling clock edge after a byte has been completely received. This works the same way in clock-idle-low (mode 0) and clock-idle-high (mode 3) operation. A separate qualifier tells the status logic whether a status write may proceed. Its value depends on the write-protect pin and on a protect bit that the status register supplies.

Top module: `spi_flash_front`

## Requirements
- R1: When chip select is high, `sdo_oe` is 0.
- R2: After reset with chip select held low, no `rx_valid` strobe is produced until chip select has gone high and then low again.
- R3: Data is sampled on rising edges of `sclk`, most significant bit first. `rx_valid` pulses for one cycle after every eighth sampled edge of a selection, and the assembled byte is then on `rx_data`.
- R4: A byte written with `tx_load` appears on `sdo` starting at the first falling edge of `sclk` after a completed received byte. Its most significant bit comes first, and each later bit is launched on the next falling edge.
- R5: Reception and transmission give identical results in mode 0 (clock idles low) and mode 3 (clock idles high).
- R6: Pulling `hold_n` low while selected drives `sdo_oe` to 0 and ignores clock and data. On release, shifting continues at the bit position where the pause began, for both received and transmitted bits.
- R7: Activity on `hold_n` while chip select is high has no effect on later reception.
- R8: `sr_wr_ok` is 0 exactly when `wp_n` is 0 and `srp` is 1; otherwise it is 1.
- R9: Raising chip select in the middle of a byte discards the partial byte without a strobe. The next selection starts at bit 7.
- R10: `rx_opcode` is 1 with the first byte of each selection and 0 with every later byte.
- R11: `sdo_oe` is 1 only when the block is selected, not paused, and `tx_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| hold_n | input | 1 | Pause request, active low |
| wp_n | input | 1 | Write protect, active low |
| srp | input | 1 | Status-register protect bit from status logic |
| tx_en | input | 1 | Decoder requests output drive |
| tx_load | input | 1 | Strobe that writes `tx_data` for transmission |
| tx_data | input | 8 | Byte to transmit |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_opcode | output | 1 | Marks the strobed byte as the first of its selection |
| sdo | output | 1 | Serial data out value |
| sdo_oe | output | 1 | Output enable for `sdo` |
| sr_wr_ok | output | 1 | Status-register write allowed |

## Verification
The assertions assume that every pin is held for several system clock cycles between changes. This lets the synchronized edges arrive in the same order as the pin edges, and it means an edge of `sclk` never coincides with a change of `cs_n` or `hold_n`. The stimulus keeps each serial clock half period at eight system cycles. It waits several cycles after every select, deselect or pause change. It enters and leaves a pause only while `sclk` rests at its idle level.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;
    typedef enum logic [1:0] {
        ST_LOCKED = 2'd0,
        ST_IDLE   = 2'd1,
        ST_ACTIVE = 2'd2,
        ST_HOLD   = 2'd3
    } fe_state_t;
endpackage

// File: rtl/spi_fe_sync.sv
module spi_fe_sync #(
    parameter int WIDTH = 5,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [STAGES-1:0][WIDTH-1:0] stg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg <= {STAGES{RST_VAL}};
        end else begin
            for (int s = STAGES - 1; s > 0; s--) begin
                stg[s] <= stg[s-1];
            end
            stg[0] <= d_i;
        end
    end

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/spi_fe_ctrl.sv
module spi_fe_ctrl
    import spi_fe_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cs_n_s,
    input  logic      hold_n_s,
    output fe_state_t state_o,
    output logic      shift_en,
    output logic      selected,
    output logic      frame_clr
);
    fe_state_t state;

    // State register with next-state selection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_LOCKED;
        end else begin
            unique case (state)
                ST_LOCKED: if (cs_n_s) state <= ST_IDLE;
                ST_IDLE:   if (!cs_n_s) state <= ST_ACTIVE;
                ST_ACTIVE: begin
                    if (cs_n_s)        state <= ST_IDLE;
                    else if (!hold_n_s) state <= ST_HOLD;
                end
                ST_HOLD: begin
                    if (cs_n_s)        state <= ST_IDLE;
                    else if (hold_n_s) state <= ST_ACTIVE;
                end
                default: state <= ST_LOCKED;
            endcase
        end
    end

    // Outputs decoded from state
    always_comb begin
        shift_en  = 1'b0;
        selected  = 1'b0;
        frame_clr = 1'b1;
        unique case (state)
            ST_LOCKED, ST_IDLE: ;
            ST_ACTIVE: begin
                shift_en  = 1'b1;
                selected  = 1'b1;
                frame_clr = 1'b0;
            end
            ST_HOLD: begin
                selected  = 1'b1;
                frame_clr = 1'b0;
            end
            default: ;
        endcase
    end

    assign state_o = state;

    // R2: a locked device stays locked while select is still low
    p_lock_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOCKED && !cs_n_s) |=> state == ST_LOCKED);

    // R7: a pause can only start from a selected state
    p_hold_from_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) |-> ($past(state) == ST_ACTIVE || $past(state) == ST_HOLD));
endmodule

// File: rtl/spi_fe_rx.sv
module spi_fe_rx #(
    parameter int W = 8,
    localparam int CW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          adv,
    input  logic          din,
    output logic [W-1:0]  data_o,
    output logic          valid_o,
    output logic          opcode_o,
    output logic [CW-1:0] cnt_o
);
    logic [CW-1:0] cnt;
    logic [W-1:0]  sh;
    logic          first;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            sh       <= '0;
            first    <= 1'b1;
            data_o   <= '0;
            valid_o  <= 1'b0;
            opcode_o <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (clr) begin
                cnt   <= '0;
                first <= 1'b1;
            end else if (adv) begin
                sh <= {sh[W-2:0], din};
                if (cnt == CW'(W - 1)) begin
                    cnt      <= '0;
                    data_o   <= {sh[W-2:0], din};
                    valid_o  <= 1'b1;
                    opcode_o <= first;
                    first    <= 1'b0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    assign cnt_o = cnt;

    // R3: strobes never come back to back
    p_valid_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R9: deselection rewinds the bit position
    p_clr_rewind_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt == '0);
endmodule

// File: rtl/spi_fe_tx.sv
module spi_fe_tx #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         fall,
    input  logic         byte_done,
    input  logic         load,
    input  logic [W-1:0] load_data,
    output logic         sdo_o
);
    logic [W-1:0] hold_reg;
    logic [W-1:0] sh;
    logic         pending;
    logic         armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_reg <= '0;
            sh       <= '0;
            pending  <= 1'b0;
            armed    <= 1'b0;
        end else begin
            if (clr) begin
                armed <= 1'b0;
            end else if (byte_done) begin
                armed <= 1'b1;
            end else if (fall) begin
                armed <= 1'b0;
                if (armed && pending) begin
                    sh      <= hold_reg;
                    pending <= 1'b0;
                end else begin
                    sh <= {sh[W-2:0], 1'b0};
                end
            end
            if (load) begin
                hold_reg <= load_data;
                pending  <= 1'b1;
            end
        end
    end

    assign sdo_o = sh[W-1];

    // R4: a loaded byte stays pending until a boundary edge consumes it
    p_pending_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !(fall && armed) && !clr && !byte_done) |=> pending);
endmodule

// File: rtl/spi_flash_front.sv
module spi_flash_front
    import spi_fe_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W = $clog2(BYTE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdi,
    input  logic              hold_n,
    input  logic              wp_n,
    input  logic              srp,
    input  logic              tx_en,
    input  logic              tx_load,
    input  logic [BYTE_W-1:0] tx_data,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_opcode,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              sr_wr_ok
);
    // pin order: cs_n, sclk, sdi, hold_n, wp_n ; select resets to "not yet seen high"
    localparam logic [4:0] PIN_RST = 5'b00011;

    logic [4:0] pins_s;
    logic cs_n_s, sclk_s, sdi_s, hold_n_s, wp_n_s;
    logic sclk_q, sclk_rise, sclk_fall;
    fe_state_t state;
    logic shift_en, selected, frame_clr;
    logic [CNT_W-1:0] bit_cnt;

    spi_fe_sync #(.WIDTH(5), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d_i({cs_n, sclk, sdi, hold_n, wp_n}),
        .q_o(pins_s)
    );
    assign {cs_n_s, sclk_s, sdi_s, hold_n_s, wp_n_s} = pins_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk_s;
    end
    assign sclk_rise = shift_en &  sclk_s & ~sclk_q;
    assign sclk_fall = shift_en & ~sclk_s &  sclk_q;

    spi_fe_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cs_n_s(cs_n_s), .hold_n_s(hold_n_s),
        .state_o(state), .shift_en(shift_en),
        .selected(selected), .frame_clr(frame_clr)
    );

    spi_fe_rx #(.W(BYTE_W)) u_rx (
        .clk(clk), .rst_n(rst_n),
        .clr(frame_clr), .adv(sclk_rise), .din(sdi_s),
        .data_o(rx_data), .valid_o(rx_valid), .opcode_o(rx_opcode),
        .cnt_o(bit_cnt)
    );

    spi_fe_tx #(.W(BYTE_W)) u_tx (
        .clk(clk), .rst_n(rst_n),
        .clr(frame_clr), .fall(sclk_fall), .byte_done(rx_valid),
        .load(tx_load), .load_data(tx_data),
        .sdo_o(sdo)
    );

    assign sdo_oe   = shift_en & tx_en;
    assign sr_wr_ok = wp_n_s | ~srp;

    // R1: no drive while deselected
    p_quiet_deselect_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !selected |-> !sdo_oe);

    // R2: no strobe can leave a locked front-end
    p_locked_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOCKED) |-> !rx_valid);

    // R6: a continuing pause freezes bit position and output bit
    p_hold_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && $past(state) == ST_HOLD) |-> ($stable(bit_cnt) && $stable(sdo)));

    // R11: output drive implies selected and not paused
    p_oe_qualified_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_oe |-> (state == ST_ACTIVE));
endmodule

// File: tb/spi_flash_front_test.sv
module spi_flash_front_test;
    localparam int H = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b0, sclk = 1'b0, sdi = 1'b0, hold_n = 1'b1, wp_n = 1'b1, srp = 1'b0;
    logic tx_en = 1'b0, tx_load = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic [7:0] rx_data;
    logic rx_valid, rx_opcode, sdo, sdo_oe, sr_wr_ok;

    int n_checks = 0;
    int n_fail = 0;
    int rx_count = 0;
    logic [7:0] last_byte = 8'h00;
    logic last_op = 1'b0;
    logic oe_seen = 1'b0;
    logic mode3 = 1'b0;

    always #2 clk = ~clk;

    spi_flash_front uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .hold_n(hold_n), .wp_n(wp_n), .srp(srp), .tx_en(tx_en),
        .tx_load(tx_load), .tx_data(tx_data), .rx_data(rx_data),
        .rx_valid(rx_valid), .rx_opcode(rx_opcode), .sdo(sdo),
        .sdo_oe(sdo_oe), .sr_wr_ok(sr_wr_ok)
    );

    always @(negedge clk) begin
        if (rx_valid) begin
            rx_count  <= rx_count + 1;
            last_byte <= rx_data;
            last_op   <= rx_opcode;
        end
        if (sdo_oe) oe_seen <= 1'b1;
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b, output logic r);
        if (sclk) sclk = 1'b0;
        sdi = b;
        wait_clk(H);
        r = sdo;
        sclk = 1'b1;
        wait_clk(H);
        if (!mode3) sclk = 1'b0;
    endtask

    task automatic send_bits(input logic [7:0] b, input int hi, input int lo, inout logic [7:0] r);
        for (int i = hi; i >= lo; i--) begin
            logic rb;
            send_bit(b[i], rb);
            r[i] = rb;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic [7:0] r);
        r = 8'h00;
        send_bits(b, 7, 0, r);
        wait_clk(4);
    endtask

    task automatic select_dev();
        sclk = mode3;
        wait_clk(H);
        cs_n = 1'b0;
        wait_clk(H);
    endtask

    task automatic deselect_dev();
        sclk = mode3;
        wait_clk(H);
        cs_n = 1'b1;
        wait_clk(H);
    endtask

    task automatic load_tx(input logic [7:0] d);
        tx_data = d;
        tx_load = 1'b1;
        wait_clk(1);
        tx_load = 1'b0;
    endtask

    task automatic toggle_clk(input int n);
        for (int i = 0; i < n; i++) begin
            sdi = ~sdi;
            sclk = ~sclk;
            wait_clk(H);
            sclk = ~sclk;
            wait_clk(H);
        end
    endtask

    task automatic t_reset_lock();
        logic [7:0] r;
        cs_n = 1'b0;
        rst_n = 1'b0;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(10);
        check("R1 reset oe", int'(sdo_oe), 0);
        check("R1 reset strobe", int'(rx_valid), 0);
        send_byte(8'hFF, r);
        check("R2 locked no byte", rx_count, 0);
        deselect_dev();
        check("R1 deselected oe", int'(sdo_oe), 0);
        select_dev();
        send_byte(8'h0F, r);
        check("R2 unlock count", rx_count, 1);
        check("R2 unlock byte", int'(last_byte), 8'h0F);
        deselect_dev();
    endtask

    task automatic t_mode(input logic m3, input logic [7:0] op, input logic [7:0] arg, input logic [7:0] resp);
        logic [7:0] r;
        int c0;
        mode3 = m3;
        tx_en = 1'b1;
        c0 = rx_count;
        load_tx(resp);
        select_dev();
        send_byte(op, r);
        check(m3 ? "R5 mode3 opcode byte" : "R3 mode0 opcode byte", int'(last_byte), int'(op));
        check("R10 first flagged", int'(last_op), 1);
        send_byte(arg, r);
        check(m3 ? "R5 mode3 second byte" : "R3 second byte", int'(last_byte), int'(arg));
        check("R10 second not flagged", int'(last_op), 0);
        check(m3 ? "R5 mode3 response" : "R4 response", int'(r), int'(resp));
        check("R3 count", rx_count, c0 + 2);
        check("R11 oe while selected", int'(sdo_oe), 1);
        deselect_dev();
        check("R1 oe after deselect", int'(sdo_oe), 0);
        tx_en = 1'b0;
        mode3 = 1'b0;
    endtask

    task automatic t_hold();
        logic [7:0] r;
        logic [7:0] q;
        tx_en = 1'b1;
        load_tx(8'hC9);
        select_dev();
        send_byte(8'h11, r);
        q = 8'h00;
        send_bits(8'hB2, 7, 5, q);
        hold_n = 1'b0;
        wait_clk(6);
        check("R6 oe off in hold", int'(sdo_oe), 0);
        toggle_clk(3);
        hold_n = 1'b1;
        wait_clk(6);
        check("R6 oe back after hold", int'(sdo_oe), 1);
        send_bits(8'hB2, 4, 0, q);
        wait_clk(4);
        check("R6 byte across hold", int'(last_byte), 8'hB2);
        check("R6 response across hold", int'(q), 8'hC9);
        deselect_dev();
        tx_en = 1'b0;
    endtask

    task automatic t_abort();
        logic [7:0] r;
        int c0;
        c0 = rx_count;
        select_dev();
        r = 8'h00;
        send_bits(8'hFF, 7, 3, r);
        deselect_dev();
        check("R9 no strobe for partial", rx_count, c0);
        select_dev();
        send_byte(8'h42, r);
        check("R9 fresh byte", int'(last_byte), 8'h42);
        check("R9 single strobe", rx_count, c0 + 1);
        check("R10 opcode after reselect", int'(last_op), 1);
        deselect_dev();
    endtask

    task automatic t_hold_deselected();
        logic [7:0] r;
        int c0;
        c0 = rx_count;
        hold_n = 1'b0;
        wait_clk(6);
        toggle_clk(4);
        hold_n = 1'b1;
        wait_clk(6);
        check("R7 no strobe", rx_count, c0);
        check("R7 oe off", int'(sdo_oe), 0);
        select_dev();
        send_byte(8'h69, r);
        check("R7 byte after", int'(last_byte), 8'h69);
        check("R7 count after", rx_count, c0 + 1);
        deselect_dev();
    endtask

    task automatic t_tx_en();
        logic [7:0] r;
        tx_en = 1'b0;
        oe_seen = 1'b0;
        wait_clk(1);
        select_dev();
        send_byte(8'h77, r);
        check("R11 no oe without request", int'(oe_seen), 0);
        tx_en = 1'b1;
        wait_clk(2);
        check("R11 oe with request", int'(sdo_oe), 1);
        deselect_dev();
        tx_en = 1'b0;
    endtask

    task automatic t_wp();
        for (int k = 0; k < 4; k++) begin
            wp_n = k[0];
            srp  = k[1];
            wait_clk(6);
            check("R8 write gate", int'(sr_wr_ok), (!k[0] && k[1]) ? 0 : 1);
        end
        wp_n = 1'b1;
        srp  = 1'b0;
    endtask

    initial begin
        t_reset_lock();
        t_mode(1'b0, 8'hA5, 8'h3C, 8'h96);
        t_mode(1'b1, 8'hC3, 8'h81, 8'h5A);
        t_hold();
        t_abort();
        t_hold_deselected();
        t_tx_en();
        t_wp();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule